// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block performs the arithmetic and logical step of a small stack-based processor. It takes two 64-bit operands, A and B, and a 4-bit function code. From these it forms a result in the same cycle: B plus A, B minus A, B AND A, or B XOR A. A 4-bit function code outside the supported set raises an invalid-function output.

Next to the datapath sits a three-flag register: zero, sign and overflow. A condition evaluator reads the stored flags and produces the taken/not-taken decision for conditional jumps and conditional moves.

The sequencer raises the flag-update enable only while an arithmetic or logical instruction executes. When the enable is low, as for moves, jumps, stack and memory operations, the stored flags stay as they are. The data pins are plain combinational inputs and outputs sampled by the surrounding pipeline. The block never stalls, so there is no valid/ready pairing and no back-pressure: an operation is accepted every cycle, and the flags commit on the rising clock edge.

Top module: `alu_cc_top`

## Requirements
- R1: The result is combinational and, taken modulo 2^64, is B+A for function 0, B-A for function 1, B&A for function 2 and B^A for function 3.
- R2: For function codes 4 to 15, `invalid` is 1 and the flags do not change at the next edge even with `flag_en` high. For codes 0 to 3, `invalid` is 0.
- R3: On a rising edge with `flag_en` high and a valid code, ZF takes (result == 0) and SF takes result bit 63.
- R4: For addition, OF takes 1 when A[63] equals B[63] and result[63] differs from them, and 0 otherwise.
- R5: For subtraction, OF takes 1 when A[63] differs from B[63] and result[63] differs from B[63], and 0 otherwise.
- R6: For AND and XOR, OF takes 0.
- R7: With `flag_en` low, the flags keep their values across the edge.
- R8: While reset (`rst_n` low, asynchronous) is asserted and after it is released, the flags read ZF=1, SF=0 and OF=0 until the first update.
- R9: `cond_true` is combinational from the stored flags. Selector 0 gives 1; 1 gives (SF^OF)|ZF; 2 gives SF^OF; 3 gives ZF; 4 gives !ZF; 5 gives !(SF^OF); 6 gives !(SF^OF)&!ZF.
- R10: Selector values 7 to 15 give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| func | input | 4 | Function code |
| flag_en | input | 1 | Flag-update enable |
| cond_sel | input | 4 | Condition selector |
| result | output | 64 | ALU result |
| invalid | output | 1 | Unsupported function code |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Condition evaluates true |

## Verification
Random operands come from a stream mixed with sign-boundary values such as 0, all-ones, the most positive and the most negative number. The mix makes both overflow rules and the zero result occur often, which separates a correct overflow equation from one that uses the wrong operand's sign. Directed cases hit exact overflow at each boundary for add and subtract, results equal to zero, and invalid codes with the enable high. They also toggle the enable, which shows that the flags are written only when asked. Each condition selector, including the false range, is checked against every flag state the bench reaches.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int FUNC_W = 4;
  localparam int COND_W = 4;

  localparam logic [FUNC_W-1:0] FN_ADD = 4'd0;
  localparam logic [FUNC_W-1:0] FN_SUB = 4'd1;
  localparam logic [FUNC_W-1:0] FN_AND = 4'd2;
  localparam logic [FUNC_W-1:0] FN_XOR = 4'd3;

  localparam logic [COND_W-1:0] CS_ALWAYS = 4'd0;
  localparam logic [COND_W-1:0] CS_LE     = 4'd1;
  localparam logic [COND_W-1:0] CS_LT     = 4'd2;
  localparam logic [COND_W-1:0] CS_EQ     = 4'd3;
  localparam logic [COND_W-1:0] CS_NE     = 4'd4;
  localparam logic [COND_W-1:0] CS_GE     = 4'd5;
  localparam logic [COND_W-1:0] CS_GT     = 4'd6;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [FUNC_W-1:0] func,
  output logic [DATA_W-1:0] res,
  output flags_t            flags_calc,
  output logic              bad_func
);
  localparam int MSB = DATA_W - 1;

  logic ovf;

  always_comb begin
    res      = '0;
    ovf      = 1'b0;
    bad_func = 1'b0;
    case (func)
      FN_ADD: begin
        res = b + a;
        ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      FN_SUB: begin
        res = b - a;
        ovf = (a[MSB] != b[MSB]) && (res[MSB] != b[MSB]);
      end
      FN_AND: res = b & a;
      FN_XOR: res = b ^ a;
      default: bad_func = 1'b1;
    endcase
  end

  assign flags_calc.zf = (res == '0);
  assign flags_calc.sf = res[MSB];
  assign flags_calc.of = ovf;

  always_comb begin
    if (func == FN_AND || func == FN_XOR)
      a_r6_logic_no_ovf: assert (!flags_calc.of);
  end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= FLAGS_RESET;
    else if (wr_en) q <= d;
  end

  a_r7_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(d)));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  flags_t            flags,
  input  logic [COND_W-1:0] sel,
  output logic              taken
);
  logic lt;

  assign lt = flags.sf ^ flags.of;

  always_comb begin
    case (sel)
      CS_ALWAYS: taken = 1'b1;
      CS_LE:     taken = lt | flags.zf;
      CS_LT:     taken = lt;
      CS_EQ:     taken = flags.zf;
      CS_NE:     taken = !flags.zf;
      CS_GE:     taken = !lt;
      CS_GT:     taken = !lt && !flags.zf;
      default:   taken = 1'b0;
    endcase
  end

  always_comb begin
    if (sel > CS_GT) a_r10_false_range: assert (!taken);
  end
endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FUNC_W-1:0] func,
  input  logic              flag_en,
  input  logic [COND_W-1:0] cond_sel,
  output logic [DATA_W-1:0] result,
  output logic              invalid,
  output logic              flag_zf,
  output logic              flag_sf,
  output logic              flag_of,
  output logic              cond_true
);
  flags_t next_flags;
  flags_t cur_flags;
  logic   commit;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .a(op_a), .b(op_b), .func(func),
    .res(result), .flags_calc(next_flags), .bad_func(invalid)
  );

  assign commit = flag_en && !invalid;

  cc_reg u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .d(next_flags), .q(cur_flags)
  );

  cond_eval u_cond (
    .flags(cur_flags), .sel(cond_sel), .taken(cond_true)
  );

  assign flag_zf = cur_flags.zf;
  assign flag_sf = cur_flags.sf;
  assign flag_of = cur_flags.of;

  a_r2_invalid_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && func > FN_XOR) |=> $stable({flag_zf, flag_sf, flag_of}));
  a_r6_logic_clears_of: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && (func == FN_AND || func == FN_XOR)) |=> !flag_of);
  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && !invalid) |=> (flag_zf == ($past(result) == '0)));
endmodule

// File: tb/alu_cc_top_tb_top.sv
module alu_cc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  func = '0;
  logic        flag_en = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [63:0] result;
  logic        invalid, flag_zf, flag_sf, flag_of, cond_true;

  int checks = 0;
  int errors = 0;
  logic ez, es, eo;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_cc_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .func(func),
    .flag_en(flag_en), .cond_sel(cond_sel), .result(result),
    .invalid(invalid), .flag_zf(flag_zf), .flag_sf(flag_sf),
    .flag_of(flag_of), .cond_true(cond_true)
  );

  function automatic logic [63:0] m_res(logic [63:0] a, logic [63:0] b, logic [3:0] f);
    case (f)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return b & a;
      4'd3: return b ^ a;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic m_of(logic [63:0] a, logic [63:0] b, logic [3:0] f);
    logic [63:0] r;
    r = m_res(a, b, f);
    if (f == 4'd0) return (a[63] == b[63]) && (r[63] != a[63]);
    if (f == 4'd1) return (a[63] != b[63]) && (r[63] != b[63]);
    return 1'b0;
  endfunction

  function automatic logic m_cond(logic [3:0] s, logic z, logic sg, logic o);
    case (s)
      4'd0: return 1'b1;
      4'd1: return (sg ^ o) | z;
      4'd2: return sg ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(sg ^ o);
      4'd6: return !(sg ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic [63:0] a, logic [63:0] b, logic [3:0] f,
                      logic en, logic [3:0] c);
    logic [63:0] r;
    @(negedge clk);
    op_a = a; op_b = b; func = f; flag_en = en; cond_sel = c;
    #1;
    r = m_res(a, b, f);
    if (f <= 4'd3) chk("R1 result", result, r);
    chk("R2 invalid", {63'd0, invalid}, {63'd0, f > 4'd3});
    chk(c > 4'd6 ? "R10 cond false range" : "R9 cond table",
        {63'd0, cond_true}, {63'd0, m_cond(c, ez, es, eo)});
    if (en && f <= 4'd3) begin
      ez = (r == 64'd0); es = r[63]; eo = m_of(a, b, f);
    end
    @(posedge clk); #1;
    chk(!en ? "R7 hold zf" : (f > 4'd3 ? "R2 hold zf" : "R3 zf"),
        {63'd0, flag_zf}, {63'd0, ez});
    chk(!en ? "R7 hold sf" : (f > 4'd3 ? "R2 hold sf" : "R3 sf"),
        {63'd0, flag_sf}, {63'd0, es});
    chk(f == 4'd0 ? "R4 add of" : (f == 4'd1 ? "R5 sub of" : "R6 of"),
        {63'd0, flag_of}, {63'd0, eo});
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return 64'd0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    ez = 1'b1; es = 1'b0; eo = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    chk("R8 reset zf", {63'd0, flag_zf}, 64'd1);
    chk("R8 reset sf", {63'd0, flag_sf}, 64'd0);
    chk("R8 reset of", {63'd0, flag_of}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    // R8 flags persist after release; R9 selectors on reset flags
    for (int s = 0; s < 16; s++) step(64'd5, 64'd7, 4'd0, 1'b0, 4'(s));
    // R4 add overflow at both boundaries
    step(64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 4'd0, 1'b1, 4'd2);
    step(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 4'd0, 1'b1, 4'd1);
    // R5 sub overflow: min - 1 and max - (-1)
    step(64'd1, 64'h8000_0000_0000_0000, 4'd1, 1'b1, 4'd5);
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 4'd1, 1'b1, 4'd6);
    // R6 logic clears OF after an overflow
    step(64'hF0, 64'h0F, 4'd2, 1'b1, 4'd3);
    step(64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 4'd0, 1'b1, 4'd0);
    step(64'hAA, 64'hAA, 4'd3, 1'b1, 4'd4);
    // R2 invalid codes with enable high keep flags
    for (int f = 4; f < 16; f++) step(64'd3, 64'd9, 4'(f), 1'b1, 4'(f));
    // R7 enable low keeps flags
    step(64'd0, 64'd0, 4'd1, 1'b0, 4'd3);
    for (int i = 0; i < 3000; i++)
      step(pick(), pick(), 4'($urandom % ((i % 8 == 0) ? 16 : 4)),
           1'($urandom % 4 != 0), 4'($urandom % 16));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule